// File: doc/BRIEF.md
# Receive Collision Counter with Overflow Interrupt

This block keeps a running tally of the collisions that a network receiver reports. Each single-cycle collision pulse adds one to an 8-bit register-style counter. The host reads that counter through a read strobe. The read returns the current value, and the counter then starts again from zero. The counter does not stop at its top value. It wraps, and on each wrap it sets a sticky overflow status bit. While the host leaves that source unmasked, the status bit drives an active-low interrupt line low.

Alongside the free-running counter, a second tally counts the collisions within the current frame. This tally stops at 255 instead of wrapping. At the end of each frame it is copied into a frame status field and then restarts. A hardware reset clears all of this state, and so does a synchronous software reset.

Top module: `rx_coll_counter`

## Requirements
- R1: After the hardware reset is released, the count on `rd_data` is 0, `frame_coll` is 0, `ovf_status` is 0 and `irq_n` is 1.
- R2: A collision pulse in a cycle with no read and no software reset raises the count by one, provided the count is below 255.
- R3: `rd_data` always shows the current count. A read strobe without a collision leaves the count at 0 in the following cycle.
- R4: A read strobe and a collision in the same cycle leave the count at 1. This holds even when the count was 255, and in that case no overflow is flagged.
- R5: A collision at a count of 255 with no read wraps the count to 0 and sets `ovf_status`.
- R6: `ovf_status` stays set until a cycle with `ovf_clr` high. When a wrap and `ovf_clr` fall in the same cycle, the bit ends up set.
- R7: `irq_n` is 0 exactly when `ovf_status` is 1 and `ovf_mask` is 0. A mask value of 1 blocks the source.
- R8: The per-frame tally saturates at 255. A cycle with `frame_end` high loads `frame_coll` with the tally, counting any collision in that same cycle, and restarts the tally at 0. At all other times `frame_coll` holds its value.
- R9: A cycle with `sw_reset` high clears the count, the per-frame tally, `frame_coll` and `ovf_status`, whatever the other inputs are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_reset | input | 1 | Synchronous software reset, one cycle |
| coll_pulse | input | 1 | One collision reported by the receiver |
| rd_strobe | input | 1 | Host read of the count; clears it |
| rd_data | output | 8 | Current count value |
| ovf_mask | input | 1 | 1 masks the overflow interrupt |
| ovf_clr | input | 1 | Clears the overflow status bit |
| ovf_status | output | 1 | Sticky overflow status |
| irq_n | output | 1 | Interrupt, active low |
| frame_end | input | 1 | Closes the current frame and latches its tally |
| frame_coll | output | 8 | Saturated collision tally of the last frame |

## Verification
Several pairs of functions can land in the same cycle.

- **Collision and read.** The bench drives both strobes in one cycle, once at a mid-range count and once at 255. It expects a count of 1 in both cases, and no overflow at 255.
- **Wrap and status clear.** The bench drives the wrapping collision in the same cycle as the clear strobe. It expects the status bit to stay set.
- **Frame end and collision.** The bench closes a frame in the same cycle as a collision. It expects the latched tally to include that collision.

// File: rtl/rxcc_pkg.sv
package rxcc_pkg;
  // Events produced by the count datapath, exposed for checking.
  typedef struct packed {
    logic bump;   // collision accepted
    logic drain;  // read cleared the count
    logic wrap;   // count rolled over
  } cnt_evt_t;
endpackage

// File: rtl/rxcc_wrap_counter.sv
module rxcc_wrap_counter #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_reset,
  input  logic                  inc,
  input  logic                  rd_clr,
  output logic [W-1:0]          count,
  output rxcc_pkg::cnt_evt_t    evt
);
  localparam logic [W-1:0] ONE = W'(1);

  // Returns {wrap flag, next count}
  function automatic logic [W:0] step_count(input logic [W-1:0] cur,
                                            input logic up,
                                            input logic clr);
    logic [W:0] sum;
    if (clr)
      step_count = {1'b0, (up ? ONE : '0)};
    else if (up) begin
      sum = {1'b0, cur} + (W+1)'(1);
      step_count = sum;
    end else
      step_count = {1'b0, cur};
  endfunction

  logic [W:0]   nxt;
  logic [W-1:0] cnt_q;

  always_comb begin
    nxt       = step_count(cnt_q, inc, rd_clr);
    evt.bump  = inc;
    evt.drain = rd_clr;
    evt.wrap  = nxt[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sw_reset) cnt_q <= '0;
    else               cnt_q <= nxt[W-1:0];
  end

  assign count = cnt_q;
endmodule

// File: rtl/rxcc_sat_counter.sv
module rxcc_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_reset,
  input  logic         inc,
  input  logic         frame_end,
  output logic [W-1:0] frame_count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] cur,
                                           input logic up);
    if (up && cur != TOP) sat_add = cur + W'(1);
    else                  sat_add = cur;
  endfunction

  logic [W-1:0] tally_q, frame_q, tally_nxt;

  assign tally_nxt = sat_add(tally_q, inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_q <= '0;
      frame_q <= '0;
    end else if (sw_reset) begin
      tally_q <= '0;
      frame_q <= '0;
    end else if (frame_end) begin
      frame_q <= tally_nxt;
      tally_q <= '0;
    end else begin
      tally_q <= tally_nxt;
    end
  end

  assign frame_count = frame_q;
endmodule

// File: rtl/rxcc_irq_ctl.sv
module rxcc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic set_evt,
  input  logic clr,
  input  logic mask,
  output logic status,
  output logic irq_n
);
  logic pend_q;

  // Set dominates clear so that a wrap is never lost.
  function automatic logic next_pend(input logic cur, input logic s,
                                     input logic c);
    next_pend = s | (cur & ~c);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (sw_reset) pend_q <= 1'b0;
    else               pend_q <= next_pend(pend_q, set_evt, clr);
  end

  assign status = pend_q;
  assign irq_n  = ~(pend_q & ~mask);
endmodule

// File: rtl/rx_coll_counter.sv
module rx_coll_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             coll_pulse,
  input  logic             rd_strobe,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ovf_mask,
  input  logic             ovf_clr,
  output logic             ovf_status,
  output logic             irq_n,
  input  logic             frame_end,
  output logic [CNT_W-1:0] frame_coll
);
  rxcc_pkg::cnt_evt_t cnt_evt;
  logic               wrap_evt;

  rxcc_wrap_counter #(.W(CNT_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .inc(coll_pulse), .rd_clr(rd_strobe),
    .count(rd_data), .evt(cnt_evt)
  );

  // A software reset suppresses the wrap event for that cycle.
  assign wrap_evt = cnt_evt.wrap & ~sw_reset;

  rxcc_sat_counter #(.W(CNT_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .inc(coll_pulse), .frame_end(frame_end),
    .frame_count(frame_coll)
  );

  rxcc_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
    .set_evt(wrap_evt), .clr(ovf_clr), .mask(ovf_mask),
    .status(ovf_status), .irq_n(irq_n)
  );
endmodule

// File: rtl/rx_coll_counter_chk.sv
module rx_coll_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset,
  input logic             coll_pulse,
  input logic             rd_strobe,
  input logic [CNT_W-1:0] rd_data,
  input logic             ovf_mask,
  input logic             ovf_clr,
  input logic             ovf_status,
  input logic             irq_n,
  input logic             frame_end,
  input logic [CNT_W-1:0] frame_coll
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_pulse && !rd_strobe && !sw_reset && rd_data != TOP)
    |=> rd_data == CNT_W'($past(rd_data) + 1'b1));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !coll_pulse) |=> rd_data == '0);

  // R4
  read_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && coll_pulse && !sw_reset) |=> rd_data == CNT_W'(1));

  // R5
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_pulse && !rd_strobe && !sw_reset && rd_data == TOP)
    |=> (rd_data == '0 && ovf_status));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_status && !ovf_clr && !sw_reset) |=> ovf_status);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (ovf_status && !ovf_mask));

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !sw_reset) |=> $stable(frame_coll));

  // R9
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (rd_data == '0 && frame_coll == '0 && !ovf_status));
endmodule

bind rx_coll_counter rx_coll_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .coll_pulse(coll_pulse),
  .rd_strobe(rd_strobe), .rd_data(rd_data), .ovf_mask(ovf_mask),
  .ovf_clr(ovf_clr), .ovf_status(ovf_status), .irq_n(irq_n),
  .frame_end(frame_end), .frame_coll(frame_coll)
);

// File: tb/rx_coll_counter_bench.sv
`timescale 1ns/100ps
module rx_coll_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_reset = 1'b0, coll_pulse = 1'b0, rd_strobe = 1'b0;
  logic       ovf_mask = 1'b0, ovf_clr = 1'b0, frame_end = 1'b0;
  logic [7:0] rd_data, frame_coll;
  logic       ovf_status, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_coll_counter u_rx_coll_counter (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .coll_pulse(coll_pulse),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .ovf_mask(ovf_mask),
    .ovf_clr(ovf_clr), .ovf_status(ovf_status), .irq_n(irq_n),
    .frame_end(frame_end), .frame_coll(frame_coll)
  );

  typedef enum int {K_CNT, K_OVF, K_IRQ, K_FRM} kind_t;
  typedef struct {
    kind_t kind;
    int    exp;
    string req;
  } item_t;
  item_t sb[$];

  task automatic push(kind_t k, int e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  // One clock with the given strobes. Inputs change 1 ns after the falling edge.
  task automatic step(logic c, logic r, logic fe, logic cl, logic sw);
    @(negedge clk); #1;
    coll_pulse = c; rd_strobe = r; frame_end = fe; ovf_clr = cl; sw_reset = sw;
    @(posedge clk); #0.1;
    coll_pulse = 0; rd_strobe = 0; frame_end = 0; ovf_clr = 0; sw_reset = 0;
  endtask

  task automatic colls(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  task automatic set_mask(logic m);
    @(negedge clk); #1;
    ovf_mask = m;
    @(posedge clk); #0.1;
  endtask

  // Monitor: compares the queued expectations at each falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.kind)
        K_CNT:   act = int'(rd_data);
        K_OVF:   act = int'(ovf_status);
        K_IRQ:   act = int'(irq_n);
        default: act = int'(frame_coll);
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d",
                 it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    // R1
    push(K_CNT, 0, "R1"); push(K_OVF, 0, "R1");
    push(K_IRQ, 1, "R1"); push(K_FRM, 0, "R1");

    // R2
    colls(3);
    push(K_CNT, 3, "R2");
    // R3: the read returns 3, then the count is 0
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    push(K_CNT, 0, "R3");

    // R4: read and collision together at a mid-range count
    colls(2);
    push(K_CNT, 2, "R4");
    step(1, 1, 0, 0, 0);
    push(K_CNT, 1, "R4");

    // R5: wrap
    step(0, 1, 0, 0, 0);
    colls(255);
    push(K_CNT, 255, "R5"); push(K_OVF, 0, "R5");
    colls(1);
    push(K_CNT, 0, "R5"); push(K_OVF, 1, "R5");
    // R7
    push(K_IRQ, 0, "R7");
    set_mask(1);
    push(K_IRQ, 1, "R7");
    set_mask(0);
    push(K_IRQ, 0, "R7");

    // R6: hold, then clear, then set wins over clear
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    push(K_OVF, 1, "R6");
    step(0, 0, 0, 1, 0);
    push(K_OVF, 0, "R6"); push(K_IRQ, 1, "R7");
    colls(255);
    step(1, 0, 0, 1, 0);
    push(K_CNT, 0, "R6"); push(K_OVF, 1, "R6");

    // R4: read and collision together at 255 give 1 and no overflow
    step(0, 0, 0, 1, 0);
    colls(255);
    push(K_CNT, 255, "R4");
    step(1, 1, 0, 0, 0);
    push(K_CNT, 1, "R4"); push(K_OVF, 0, "R4");

    // R8: the per-frame tally is far past 255 and saturated
    step(0, 0, 1, 0, 0);
    push(K_FRM, 255, "R8");
    colls(2);
    push(K_FRM, 255, "R8");
    step(1, 0, 1, 0, 0);
    push(K_FRM, 3, "R8");
    step(0, 0, 1, 0, 0);
    push(K_FRM, 0, "R8");

    // R9: count 4 plus 260 collisions gives 8, with a wrap
    colls(260);
    push(K_CNT, 8, "R9"); push(K_OVF, 1, "R9");
    step(0, 0, 1, 0, 0);
    push(K_FRM, 255, "R9");
    colls(2);
    push(K_CNT, 10, "R9"); push(K_IRQ, 0, "R9");
    step(1, 0, 0, 0, 1);
    push(K_CNT, 0, "R9"); push(K_OVF, 0, "R9");
    push(K_IRQ, 1, "R9"); push(K_FRM, 0, "R9");
    step(0, 0, 1, 0, 0);
    push(K_FRM, 0, "R9");

    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule